// File: doc/BRIEF.md
# Quadrature Clock Phase Calibration Controller

This block decides when the receiver re-measures the phase offset between its in-phase (I) and quadrature (Q) clocks, and it performs that measurement. A run always starts on the first clock after reset. Further runs start either on a one-cycle transceive-complete pulse or on a software write that takes the control bit from 0 to 1. Each run holds `busy_o` high for a fixed number of oscillator cycles. During the run, the block counts cycles from a rising edge of the sampled I clock to the next rising edge of the sampled Q clock, and it also measures one full I period.

When the run ends, the count is stored as a delay code. A wide-phase flag is loaded at the same time. It is high when the offset is more than half of the measured I period, which means more than 180 degrees.

The control bit, `ctl_o`, has two jobs. While it is 0, every transceive-complete pulse starts a run. While it is 1, those pulses are ignored. Software can load a delay code of its own, but the block accepts that write only after the control bit has been 1 for at least one run length. This prevents an automatic run from later replacing the loaded value.

Top module: `qcal_phase_cal`

## Requirements
- R1: The first clock edge after reset is released starts a run, whatever the control bit holds. The control bit resets to 0.
- R2: When the control bit is 0 and no run is active, a `xfer_done_i` pulse makes `busy_o` high from the next cycle.
- R3: When the control bit is 1, `xfer_done_i` pulses start no run.
- R4: A write that sets the control bit from 0 to 1 starts one run. Writing 1 while the bit is already 1 starts none.
- R5: `busy_o` stays high for exactly RUN_LEN (65) consecutive cycles per run.
- R6: At the end of a run, `code_o` holds the number of cycles from the first sampled rising edge of I to the next sampled rising edge of Q. Coincident edges give 0. The count saturates at 63. A run that sees no I rising edge gives 0.
- R7: At the end of every run, `wide_o` is loaded. It is 1 when twice the code exceeds the I period measured between two I rising edges in the same run. Otherwise it is 0.
- R8: A code write is accepted only if the control bit has been 1 for at least RUN_LEN cycles. Any other code write leaves `code_o` unchanged.
- R9: After the control bit returns to 0, the next automatic run replaces a code that software loaded.
- R10: A trigger that arrives while a run is active is dropped and does not queue a later run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_smp_i | input | 1 | Sampled in-phase clock |
| q_smp_i | input | 1 | Sampled quadrature clock |
| xfer_done_i | input | 1 | One-cycle transceive-complete pulse |
| ctl_wr_i | input | 1 | Write strobe for the control bit |
| ctl_wr_val_i | input | 1 | Value written to the control bit |
| code_wr_i | input | 1 | Write strobe for the delay code |
| code_wr_val_i | input | 6 | Delay code written by software |
| ctl_o | output | 1 | Current control bit |
| code_o | output | 6 | Stored delay code |
| wide_o | output | 1 | Phase offset above 180 degrees |
| busy_o | output | 1 | Calibration run in progress |

## Verification
The bench drives I and Q waveforms with known period and offset. These include coincident edges, an offset of exactly half a period, an offset just above half, and an offset long enough to saturate the counter. A design with the comparison off by one would set the flag at exactly 180 degrees, and one without saturation would wrap to a small code.

A second transceive pulse is injected in the middle of a run. A design that queues triggers would raise `busy_o` again after the run ends.

A code write made while the control bit has been 1 for only 20 cycles must be ignored. A later write must be accepted. A repeated write of 1 to the control bit must not start a run, which catches a design that treats a level, rather than a rising edge, as the trigger.

// File: rtl/qcal_pkg.sv
package qcal_pkg;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef enum logic {
        MEAS_WAIT_I = 1'b0,
        MEAS_TRACK  = 1'b1
    } meas_state_e;

endpackage

// File: rtl/qcal_trigger.sv
module qcal_trigger #(
    parameter int unsigned RUN_LEN = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_done_i,
    input  logic ctl_wr_i,
    input  logic ctl_wr_val_i,
    input  logic busy_i,
    output logic start_o,
    output logic ctl_o,
    output logic wr_allow_o
);
    localparam int unsigned HOLD_W = $clog2(RUN_LEN + 1);
    localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(RUN_LEN);

    typedef struct packed {
        logic              boot;
        logic              ctl;
        logic [HOLD_W-1:0] hold;
    } trig_t;

    trig_t t_d, t_q;
    logic  sw_rise, auto_req;

    always_comb begin
        t_d      = t_q;
        sw_rise  = ctl_wr_i & ctl_wr_val_i & ~t_q.ctl;
        auto_req = xfer_done_i & ~t_q.ctl;
        start_o  = ~busy_i & (t_q.boot | auto_req | sw_rise);

        t_d.boot = 1'b0;
        if (ctl_wr_i) begin
            t_d.ctl = ctl_wr_val_i;
        end
        // hold time counts cycles spent with the bit at 1
        if (!t_q.ctl) begin
            t_d.hold = '0;
        end else if (t_q.hold != HOLD_MAX) begin
            t_d.hold = t_q.hold + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{boot: 1'b1, ctl: 1'b0, hold: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign ctl_o      = t_q.ctl;
    assign wr_allow_o = t_q.ctl & (t_q.hold == HOLD_MAX);

endmodule

// File: rtl/qcal_run_timer.sv
module qcal_run_timer
    import qcal_pkg::*;
#(
    parameter int unsigned RUN_LEN = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

    typedef struct packed {
        run_state_e       st;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        last_o = (r_q.st == RUN_ACTIVE) && (r_q.cnt == CNT_LAST);
        unique case (r_q.st)
            RUN_IDLE: begin
                if (start_i) begin
                    r_d.st  = RUN_ACTIVE;
                    r_d.cnt = '0;
                end
            end
            RUN_ACTIVE: begin
                if (last_o) begin
                    r_d.st  = RUN_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: RUN_IDLE, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st == RUN_ACTIVE);

endmodule

// File: rtl/qcal_phase_meter.sv
module qcal_phase_meter
    import qcal_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              i_smp_i,
    input  logic              q_smp_i,
    output logic [CODE_W-1:0] code_o,
    output logic              wide_o
);
    localparam int unsigned PER_W = CODE_W + 1;
    localparam logic [CODE_W-1:0] PH_MAX  = {CODE_W{1'b1}};
    localparam logic [PER_W-1:0]  PER_MAX = {PER_W{1'b1}};

    typedef struct packed {
        logic              i_prev;
        logic              q_prev;
        meas_state_e       st;
        logic              ph_done;
        logic              per_done;
        logic [CODE_W-1:0] ph;
        logic [PER_W-1:0]  per;
    } meas_t;

    meas_t m_d, m_q;
    logic  i_rise, q_rise;

    always_comb begin
        m_d        = m_q;
        i_rise     = i_smp_i & ~m_q.i_prev;
        q_rise     = q_smp_i & ~m_q.q_prev;
        m_d.i_prev = i_smp_i;
        m_d.q_prev = q_smp_i;

        if (start_i) begin
            m_d.st       = MEAS_WAIT_I;
            m_d.ph_done  = 1'b0;
            m_d.per_done = 1'b0;
            m_d.ph       = '0;
            m_d.per      = '0;
        end else if (busy_i) begin
            unique case (m_q.st)
                MEAS_WAIT_I: begin
                    if (i_rise) begin
                        m_d.st  = MEAS_TRACK;
                        m_d.per = PER_W'(1);
                        if (q_rise) begin
                            m_d.ph_done = 1'b1;
                            m_d.ph      = '0;
                        end else begin
                            m_d.ph = CODE_W'(1);
                        end
                    end
                end
                MEAS_TRACK: begin
                    if (!m_q.ph_done) begin
                        if (q_rise) begin
                            m_d.ph_done = 1'b1;
                        end else if (m_q.ph != PH_MAX) begin
                            m_d.ph = m_q.ph + 1'b1;
                        end
                    end
                    if (!m_q.per_done) begin
                        if (i_rise) begin
                            m_d.per_done = 1'b1;
                        end else if (m_q.per != PER_MAX) begin
                            m_d.per = m_q.per + 1'b1;
                        end
                    end
                end
                default: m_d = m_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{i_prev: 1'b0, q_prev: 1'b0, st: MEAS_WAIT_I,
                     ph_done: 1'b0, per_done: 1'b0, ph: '0, per: '0};
        end else begin
            m_q <= m_d;
        end
    end

    assign code_o = m_q.ph;
    assign wide_o = m_q.ph_done & m_q.per_done & ({m_q.ph, 1'b0} > m_q.per);

endmodule

// File: rtl/qcal_phase_cal.sv
module qcal_phase_cal #(
    parameter int unsigned RUN_LEN = 65,
    parameter int unsigned CODE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_smp_i,
    input  logic              q_smp_i,
    input  logic              xfer_done_i,
    input  logic              ctl_wr_i,
    input  logic              ctl_wr_val_i,
    input  logic              code_wr_i,
    input  logic [CODE_W-1:0] code_wr_val_i,
    output logic              ctl_o,
    output logic [CODE_W-1:0] code_o,
    output logic              wide_o,
    output logic              busy_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              wide;
    } res_t;

    res_t              res_d, res_q;
    logic              start, run_busy, run_last, wr_allow;
    logic [CODE_W-1:0] meas_code;
    logic              meas_wide;

    qcal_trigger #(.RUN_LEN(RUN_LEN)) u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_done_i  (xfer_done_i),
        .ctl_wr_i     (ctl_wr_i),
        .ctl_wr_val_i (ctl_wr_val_i),
        .busy_i       (run_busy),
        .start_o      (start),
        .ctl_o        (ctl_o),
        .wr_allow_o   (wr_allow)
    );

    qcal_run_timer #(.RUN_LEN(RUN_LEN)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (run_busy),
        .last_o  (run_last)
    );

    qcal_phase_meter #(.CODE_W(CODE_W)) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_i  (run_busy),
        .i_smp_i (i_smp_i),
        .q_smp_i (q_smp_i),
        .code_o  (meas_code),
        .wide_o  (meas_wide)
    );

    always_comb begin
        res_d = res_q;
        if (run_last) begin
            res_d.code = meas_code;
            res_d.wide = meas_wide;
        end else if (code_wr_i && wr_allow) begin
            res_d.code = code_wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{code: '0, wide: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    assign code_o = res_q.code;
    assign wide_o = res_q.wide;
    assign busy_o = run_busy;

endmodule

// File: rtl/qcal_phase_cal_chk.sv
module qcal_phase_cal_chk #(
    parameter int unsigned RUN_LEN = 65,
    parameter int unsigned CODE_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_done_i,
    input logic              ctl_wr_i,
    input logic              ctl_wr_val_i,
    input logic              ctl_o,
    input logic [CODE_W-1:0] code_o,
    input logic              wide_o,
    input logic              busy_o
);
    localparam int unsigned LEN_W = $clog2(RUN_LEN + 2);
    localparam logic [LEN_W-1:0] LEN_RUN = LEN_W'(RUN_LEN);
    localparam logic [LEN_W-1:0] LEN_TOP = {LEN_W{1'b1}};

    logic [LEN_W-1:0] len_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (!busy_o) begin
                len_q <= '0;
            end else if (len_q != LEN_TOP) begin
                len_q <= len_q + 1'b1;
            end
        end
    end

    p_boot_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |=> busy_o);

    p_auto_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && !ctl_o && !busy_o) |=> busy_o);

    p_ctl_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o && !busy_o) |=> !busy_o);

    p_sw_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && ctl_wr_val_i && !ctl_o && !busy_o) |=> (busy_o && ctl_o));

    p_run_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (len_q == LEN_RUN));

    p_flag_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wide_o) |-> $past(busy_o));

    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_o && !busy_o) |=> $stable(code_o));

endmodule

bind qcal_phase_cal qcal_phase_cal_chk #(.RUN_LEN(RUN_LEN), .CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_done_i  (xfer_done_i),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_wr_val_i (ctl_wr_val_i),
    .ctl_o        (ctl_o),
    .code_o       (code_o),
    .wide_o       (wide_o),
    .busy_o       (busy_o)
);

// File: tb/qcal_phase_cal_test.sv
module qcal_phase_cal_test;
    localparam int RUN = 65;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_smp = 1'b0, q_smp = 1'b0;
    logic       xfer_done = 1'b0;
    logic       ctl_wr = 1'b0, ctl_wr_val = 1'b0;
    logic       code_wr = 1'b0;
    logic [5:0] code_wr_val = '0;
    logic       ctl_o, wide_o, busy_o;
    logic [5:0] code_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // period, offset, expected code, expected flag
    localparam int VEC[7][4] = '{
        '{20,  5,  5, 0},
        '{20, 10, 10, 0},
        '{20, 11, 11, 1},
        '{16,  0,  0, 0},
        '{30, 29, 29, 1},
        '{24, 17, 17, 1},
        '{128, 70, 63, 0}
    };

    qcal_phase_cal uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .i_smp_i       (i_smp),
        .q_smp_i       (q_smp),
        .xfer_done_i   (xfer_done),
        .ctl_wr_i      (ctl_wr),
        .ctl_wr_val_i  (ctl_wr_val),
        .code_wr_i     (code_wr),
        .code_wr_val_i (code_wr_val),
        .ctl_o         (ctl_o),
        .code_o        (code_o),
        .wide_o        (wide_o),
        .busy_o        (busy_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic set_io(input int per, input int dly, input int t);
        if (per == 0) begin
            i_smp = 1'b0;
            q_smp = 1'b0;
        end else begin
            i_smp = (t % per) < (per / 2);
            q_smp = (t >= dly) && (((t - dly) % per) < (per / 2));
        end
    endtask

    // runs the waveform for 80 cycles and counts busy samples
    task automatic measure(input int per, input int dly, input int pulse_at,
                           input int cw_at, input int cw_val, output int cnt);
        cnt = busy_o ? 1 : 0;
        set_io(per, dly, 0);
        for (int t = 1; t < 80; t++) begin
            @(negedge clk);
            xfer_done = 1'b0;
            code_wr   = 1'b0;
            if (busy_o) cnt++;
            set_io(per, dly, t);
            if (t == pulse_at) xfer_done = 1'b1;
            if (t == cw_at) begin
                code_wr     = 1'b1;
                code_wr_val = 6'(cw_val);
            end
        end
        @(negedge clk);
        xfer_done = 1'b0;
        code_wr   = 1'b0;
        set_io(0, 0, 0);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic write_ctl(input logic v);
        @(negedge clk);
        ctl_wr     = 1'b1;
        ctl_wr_val = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic write_code(input int v);
        @(negedge clk);
        code_wr     = 1'b1;
        code_wr_val = 6'(v);
        @(negedge clk);
        code_wr = 1'b0;
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 ctl reset value", ctl_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 boot run starts", busy_o, 1);
        measure(0, 0, -1, -1, 0, cnt);
        chk("R5 boot run length", cnt, RUN);
        chk("R6 code without I edge", code_o, 0);
        chk("R7 flag without I edge", wide_o, 0);

        foreach (VEC[k]) begin
            pulse_done();
            chk("R2 auto run starts", busy_o, 1);
            measure(VEC[k][0], VEC[k][1], -1, -1, 0, cnt);
            chk("R5 run length", cnt, RUN);
            chk("R6 delay code", code_o, VEC[k][2]);
            chk("R7 wide flag", wide_o, VEC[k][3]);
        end

        // R10: second trigger in the middle of a run
        pulse_done();
        measure(24, 17, 30, -1, 0, cnt);
        chk("R10 dropped trigger", cnt, RUN);
        chk("R10 code", code_o, 17);
        chk("R10 flag", wide_o, 1);

        // R4 and R8: rising write starts a run, early code write ignored
        write_ctl(1'b1);
        chk("R4 rise starts run", busy_o, 1);
        chk("R4 ctl reads 1", ctl_o, 1);
        measure(20, 7, -1, 20, 33, cnt);
        chk("R4 run length", cnt, RUN);
        chk("R8 early write ignored", code_o, 7);
        chk("R7 flag after rise run", wide_o, 0);
        write_code(45);
        chk("R8 late write accepted", code_o, 45);

        write_ctl(1'b1);
        measure(20, 5, -1, -1, 0, cnt);
        chk("R4 repeated 1 no run", cnt, 0);
        chk("R4 code unchanged", code_o, 45);

        measure(20, 5, 3, -1, 0, cnt);
        chk("R3 pulse blocked", cnt, 0);
        chk("R3 code unchanged", code_o, 45);

        write_ctl(1'b0);
        chk("R4 clearing no run", busy_o, 0);
        write_code(50);
        chk("R8 write with ctl 0 ignored", code_o, 45);

        pulse_done();
        measure(20, 3, -1, -1, 0, cnt);
        chk("R9 auto run length", cnt, RUN);
        chk("R9 code replaced", code_o, 3);
        chk("R9 flag", wide_o, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule